// File: doc/BRIEF.md
# Falling-Edge Port Interrupt and Wake Unit

This unit watches a small input port for high-to-low transitions and turns them into two requests: a wake pulse for the sleep controller and a level interrupt request for the interrupt logic. The port sits in an 8-bit register space. Only bit positions 0, 1, 2 and 4 are backed by pins; the other positions have no storage.

Each implemented pin has two register bits of its own. The first is an edge-enable bit. The second is a sticky event flag that software clears. A pin takes part in detection only when its external direction bit marks it as an input and its edge-enable bit is set. Pins are first passed through a synchroniser. A falling edge is then detected on the synchronised value.

Every qualified falling edge wakes the core, out of either low-power state. An interrupt request is raised only while the separate global port-interrupt enable is high. Software writes the edge-enable register and the flag register through a single-cycle write port. Both registers are always visible on output buses.

Top module: `pwk_port_wake`

## Requirements
- R1: A falling edge on pin n counts as an event only when dir_i[n] is 1 (input) and edge-enable bit n is 1. Otherwise the edge has no effect on the flags or on wake_o.
- R2: A low-to-high transition on any pin never produces an event.
- R3: An event on pin n sets flag_o[n]. The flag stays set until software clears it.
- R4: A write with wr_sel_i = 1 clears each flag bit whose wr_data_i bit is 0 and leaves each flag bit whose data bit is 1 unchanged. An event in the same cycle as a clear leaves that flag set.
- R5: Each event gives a one-cycle pulse on wake_o, whatever the value of gie_i. The pulse and the flag update appear on the third rising clock edge after the pin falls (two synchroniser stages plus one edge-detect stage).
- R6: irq_o is high exactly when gie_i is 1 and at least one flag bit is set.
- R7: After reset the edge-enable bits and the flag bits are 0, and wake_o is 0.
- R8: Bit positions 3, 5, 6 and 7 read as 0 in both registers and ignore writes. The implemented positions are 0, 1, 2 and 4. A write with wr_sel_i = 0 loads the edge-enable register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_i | input | 8 | Raw port pin levels |
| dir_i | input | 8 | Pin direction, 1 = input |
| gie_i | input | 1 | Global port-interrupt enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Register select: 0 edge-enable, 1 flags |
| wr_data_i | input | 8 | Write data |
| en_o | output | 8 | Edge-enable register contents |
| flag_o | output | 8 | Event flag register contents |
| wake_o | output | 1 | One-cycle wake pulse |
| irq_o | output | 1 | Port interrupt request |

## Verification
The bench sweeps every one of the eight bit positions, in every combination of edge-enable and direction, with a falling edge followed by a rising edge. This shows whether detection is qualified correctly, whether implemented and unimplemented positions are told apart, and whether rising edges are ignored. The timing of the wake pulse is checked at its exact cycle and one cycle later, with gie_i low, so that wake is separated from interrupt. Flag clearing is tried with all-ones, partial and all-zeros write patterns, and with a clear that lands in the same cycle as an event. The interrupt output is checked against gie_i with flags both set and empty.

// File: rtl/pwk_pkg.sv
package pwk_pkg;
  localparam int unsigned PortWidth = 8;
  localparam logic [PortWidth-1:0] PinMask = 8'h17;
  localparam int unsigned SyncStages = 2;
  typedef enum logic {SelEnable = 1'b0, SelFlags = 1'b1} reg_sel_e;
endpackage

// File: rtl/pwk_rst_sync.sv
module pwk_rst_sync (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_no = hold_q;
endmodule

// File: rtl/pwk_sync.sv
module pwk_sync #(
  parameter int unsigned W = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] prev_q;

  // Stages and the previous-value register reset low, so no falling
  // edge can be seen until a pin has first been sampled high.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(STAGES); i++) stage_q[i] <= '0;
      prev_q <= '0;
    end else begin
      stage_q[0] <= pin_i;
      for (int i = 1; i < int'(STAGES); i++) stage_q[i] <= stage_q[i-1];
      prev_q <= stage_q[STAGES-1];
    end
  end

  assign cur_o = stage_q[STAGES-1];

  for (genvar b = 0; b < int'(W); b++) begin : g_fall
    assign fall_o[b] = prev_q[b] & ~cur_o[b];
  end
endmodule

// File: rtl/pwk_regs.sv
module pwk_regs #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] MASK = 8'h17
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic         wr_sel_i,
  input  logic [W-1:0] wr_data_i,
  input  logic [W-1:0] evt_i,
  output logic [W-1:0] en_o,
  output logic [W-1:0] flag_o
);
  import pwk_pkg::*;

  logic [W-1:0] en_q, en_d;
  logic [W-1:0] flag_q, flag_d;
  logic         en_we;
  logic         flag_we;

  assign en_we   = wr_en_i && (reg_sel_e'(wr_sel_i) == SelEnable);
  assign flag_we = wr_en_i && (reg_sel_e'(wr_sel_i) == SelFlags);

  always_comb begin
    en_d   = en_q;
    flag_d = flag_q;
    if (en_we) en_d = wr_data_i & MASK;
    if (flag_we) flag_d = flag_q & wr_data_i;
    // A new event wins over a clear in the same cycle.
    flag_d = (flag_d | evt_i) & MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      flag_q <= '0;
    end else begin
      if (en_we) en_q <= en_d;
      flag_q <= flag_d;
    end
  end

  assign en_o   = en_q;
  assign flag_o = flag_q;

  a_r3_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_we |=> ((flag_o & $past(flag_o)) == $past(flag_o)));

  a_r8_unimpl_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (((en_o | flag_o) & ~MASK) == '0));
endmodule

// File: rtl/pwk_port_wake.sv
module pwk_port_wake #(
  parameter int unsigned W = pwk_pkg::PortWidth,
  parameter logic [W-1:0] MASK = pwk_pkg::PinMask,
  parameter int unsigned STAGES = pwk_pkg::SyncStages
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  input  logic [W-1:0] dir_i,
  input  logic         gie_i,
  input  logic         wr_en_i,
  input  logic         wr_sel_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] en_o,
  output logic [W-1:0] flag_o,
  output logic         wake_o,
  output logic         irq_o
);
  logic         rst_n;
  logic [W-1:0] cur;
  logic [W-1:0] fall;
  logic [W-1:0] evt;
  logic         wake_d;
  logic         wake_q;

  pwk_rst_sync u_rst (
    .clk_i  (clk_i),
    .arst_ni(rst_ni),
    .rst_no (rst_n)
  );

  pwk_sync #(.W(W), .STAGES(STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_n),
    .pin_i (pin_i),
    .cur_o (cur),
    .fall_o(fall)
  );

  assign evt = fall & dir_i & en_o & MASK;

  pwk_regs #(.W(W), .MASK(MASK)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .wr_en_i  (wr_en_i),
    .wr_sel_i (wr_sel_i),
    .wr_data_i(wr_data_i),
    .evt_i    (evt),
    .en_o     (en_o),
    .flag_o   (flag_o)
  );

  assign wake_d = |evt;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) wake_q <= 1'b0;
    else        wake_q <= wake_d;
  end

  assign wake_o = wake_q;
  assign irq_o  = gie_i & (|flag_o);

  a_r5_wake_marks_flag: assert property (@(posedge clk_i) disable iff (!rst_n)
    wake_o |-> (flag_o != '0));

  a_r1_wake_qualified: assert property (@(posedge clk_i) disable iff (!rst_n)
    wake_o |-> ($past(dir_i & en_o & MASK) != '0));

  a_r2_wake_after_low: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(wake_o) |-> ((cur & $past(dir_i & en_o & MASK)) != $past(dir_i & en_o & MASK)));
endmodule

// File: tb/sim_pwk_port_wake.sv
module sim_pwk_port_wake;
  localparam logic [7:0] IMPL = 8'b0001_0111;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] pin, dir, wdata;
  logic       gie, wr_en, wr_sel;
  logic [7:0] en_o, flag_o;
  logic       wake_o, irq_o;
  int         checks = 0;
  int         errors = 0;
  bit         done = 0;

  always #5 clk = ~clk;

  pwk_port_wake u0 (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .dir_i(dir), .gie_i(gie),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wdata),
    .en_o(en_o), .flag_o(flag_o), .wake_o(wake_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 8'h1, 8'h0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pin = 8'hFF; dir = 8'hFF; gie = 1'b1;
    wr_en = 1'b0; wr_sel = 1'b0; wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R7 enable reset", en_o, 8'h00);
    chk("R7 flag reset", flag_o, 8'h00);
    chk("R7 wake reset", {7'b0, wake_o}, 8'h00);
    chk("R6 irq idle", {7'b0, irq_o}, 8'h00);

    // R8 write all ones to enable register
    wr(1'b0, 8'hFF);
    chk("R8 enable mask", en_o, IMPL);
    gie = 1'b0;

    // Sweep: pin x enable x direction (R1 R2 R3 R5 R8)
    for (int p = 0; p < 8; p++) begin
      for (int e = 0; e < 2; e++) begin
        for (int d = 0; d < 2; d++) begin
          logic [7:0] bitv;
          logic       expv;
          bitv = 8'h01 << p;
          expv = (e == 1) && (d == 1) && IMPL[p];
          pin = 8'hFF;
          dir = (d == 1) ? 8'hFF : ~bitv;
          wr(1'b0, (e == 1) ? bitv : 8'h00);
          wr(1'b1, 8'h00);
          repeat (4) @(negedge clk);
          chk("R8 enable readback", en_o, (e == 1) ? (bitv & IMPL) : 8'h00);
          pin = ~bitv;
          repeat (3) @(posedge clk);
          @(negedge clk);
          chk("R5 wake pulse", {7'b0, wake_o}, {7'b0, expv});
          chk("R1 R3 flag set", flag_o, expv ? bitv : 8'h00);
          chk("R6 irq gated off", {7'b0, irq_o}, 8'h00);
          @(negedge clk);
          chk("R5 wake one cycle", {7'b0, wake_o}, 8'h00);
          pin = 8'hFF;
          repeat (5) @(negedge clk);
          chk("R2 rise ignored wake", {7'b0, wake_o}, 8'h00);
          chk("R2 R3 flag kept", flag_o, expv ? bitv : 8'h00);
        end
      end
    end

    // Fill all flags (R3), then clear patterns (R4)
    dir = 8'hFF;
    wr(1'b0, 8'hFF);
    wr(1'b1, 8'h00);
    pin = 8'h00;
    repeat (5) @(negedge clk);
    chk("R3 all flags", flag_o, IMPL);
    chk("R6 irq off gie0", {7'b0, irq_o}, 8'h00);
    gie = 1'b1;
    #1;
    chk("R6 irq on", {7'b0, irq_o}, 8'h01);
    wr(1'b1, 8'hFF);
    chk("R4 write ones keep", flag_o, IMPL);
    wr(1'b1, 8'hFB);
    chk("R4 partial clear", flag_o, IMPL & 8'hFB);
    wr(1'b1, 8'h00);
    chk("R4 full clear", flag_o, 8'h00);
    #1;
    chk("R6 irq off no flag", {7'b0, irq_o}, 8'h00);

    // R4 event coincides with clear
    pin = 8'hFF;
    repeat (5) @(negedge clk);
    pin = 8'hFE;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 1'b1; wdata = 8'h00;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    chk("R4 event beats clear", flag_o, 8'h01);
    chk("R5 wake with gie1", {7'b0, wake_o}, 8'h01);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule